// File: doc/BRIEF.md
# GPIO Input Glitch Filter with Shared Divided Tick

This block cleans up a bank of general-purpose input pins before the rest of the chip sees them. Every pin first passes through a two-flop synchronizer. After that, each pin can be left unfiltered, filtered at the raw clock rate, or filtered at a slower rate set by one programmable divider that all pins share. A filtered pin changes its output only when two consecutive samples agree with each other and differ from the present output. A pulse that lasts less than one sample period therefore never reaches the output.

The divider produces a one-cycle tick every 2 × (divide value + 1) clock cycles. The divide value is 24 bits wide by default, so the longest tick period is 2^25 clock cycles. Each pin has two control bits. The first turns its filter on. The second selects whether that filter samples on the divided tick or on every clock. Writing a new divide value restarts the divider count from zero.

When reset is released, the block spends a few cycles loading every output from the synchronized input, whatever the control bits say. Outputs therefore start from the real pin levels and not from an arbitrary constant.

Top module: `gpio_debounce_filter`

## Requirements
- R1: While reset is asserted every output bit is 0. During the first three clocks after reset is released, each output takes its synchronized input regardless of the enable and select bits, so an input held steady from release shows on the output after the third clock edge.
- R2: A pin whose filter enable is 0 drives its output with its input delayed by exactly three clock edges: two for the synchronizer and one for the output register. Every pulse, however short, passes.
- R3: A pin with filter enable 1 and select 0 samples every clock. A held level change reaches the output on the fourth clock edge after it is applied, and a pulse lasting a single clock cycle never reaches the output.
- R4: The shared tick repeats every 2 × (D + 1) clock cycles, where D is the divide value.
- R5: A pin with filter enable 1 and select 1 changes its output only on a clock edge with the tick high. It changes only when the synchronized level at that tick equals the level captured at the previous tick and differs from the output.
- R6: A divide value that differs from the one seen on the previous clock restarts the tick count at zero. The first tick then arrives 2 × (D + 1) cycles after the change is registered.
- R7: Each pin follows only its own enable and select bits. Pins in different modes share one bank without affecting one another.
- R8: The all-ones divide value is accepted and gives the longest period, 2^(DIV_W+1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Filter clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_raw_i | input | NPINS | Asynchronous pin levels |
| dbnc_en_i | input | NPINS | Per-pin filter enable |
| slow_sel_i | input | NPINS | Per-pin select: 1 = divided tick, 0 = every clock |
| div_val_i | input | DIV_W | Shared divide value D |
| pin_filt_o | output | NPINS | Filtered pin levels |

## Verification
An input change is due at an unfiltered output after the third clock edge and at a filtered output after the fourth clock edge in raw-clock mode. In divided mode it is due at the second tick that sees the new level, with ticks counted from the last divide-value change. The bench drives inputs on falling edges and reads outputs on the next falling edge. It compares every cycle against a cycle model built from these latencies. Directed checks sample one edge before and exactly at the due edge for the reset load, the three-edge pass-through and the four-edge filtered change.

// File: rtl/gpdb_pkg.sv
package gpdb_pkg;
  // Clocks after reset release during which outputs load from the synchronizer
  localparam int unsigned LOAD_CYC = 3;
  localparam int unsigned LOAD_W   = $clog2(LOAD_CYC + 1);

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_FAST = 2'd1,
    MODE_SLOW = 2'd2
  } filt_mode_e;
endpackage

// File: rtl/gpdb_sync.sv
module gpdb_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st1_q, st2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st1_q <= '0;
      st2_q <= '0;
    end else begin
      st1_q <= d_i;
      st2_q <= st1_q;
    end
  end

  assign q_o = st2_q;
endmodule

// File: rtl/gpdb_tick.sv
module gpdb_tick #(
  parameter int unsigned DIV_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic [DIV_W:0]   cnt_o,
  output logic [DIV_W-1:0] div_q_o
);
  localparam int unsigned CW = DIV_W + 1;

  logic [CW-1:0]    cnt_q, cnt_d;
  logic [DIV_W-1:0] div_q;
  logic [CW-1:0]    term;
  logic             chg;

  always_comb begin
    term   = {div_i, 1'b1};
    chg    = (div_i != div_q);
    tick_o = !chg && (cnt_q == term);
    if (chg || tick_o) cnt_d = '0;
    else               cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_i;
    end
  end

  assign cnt_o   = cnt_q;
  assign div_q_o = div_q;
endmodule

// File: rtl/gpdb_pin_filter.sv
module gpdb_pin_filter
  import gpdb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic en_i,
  input  logic sel_i,
  input  logic tick_i,
  input  logic sync_i,
  output logic filt_o
);
  filt_mode_e mode;
  logic       smp_en;
  logic       samp_q, samp_d;
  logic       filt_q, filt_d;

  always_comb begin
    if (!en_i)      mode = MODE_PASS;
    else if (sel_i) mode = MODE_SLOW;
    else            mode = MODE_FAST;
    smp_en = (mode == MODE_FAST) || ((mode == MODE_SLOW) && tick_i);
    samp_d = samp_q;
    filt_d = filt_q;
    if (load_i || (mode == MODE_PASS)) begin
      samp_d = sync_i;
      filt_d = sync_i;
    end else if (smp_en) begin
      samp_d = sync_i;
      if (sync_i == samp_q) filt_d = sync_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= 1'b0;
      filt_q <= 1'b0;
    end else begin
      samp_q <= samp_d;
      filt_q <= filt_d;
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/gpio_debounce_filter.sv
module gpio_debounce_filter
  import gpdb_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned DIV_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_raw_i,
  input  logic [NPINS-1:0] dbnc_en_i,
  input  logic [NPINS-1:0] slow_sel_i,
  input  logic [DIV_W-1:0] div_val_i,
  output logic [NPINS-1:0] pin_filt_o
);
  logic [NPINS-1:0]  pin_sync;
  logic              tick_on;
  logic [DIV_W:0]    tick_cnt;
  logic [DIV_W-1:0]  div_held;
  logic [LOAD_W-1:0] ld_q, ld_d;
  logic              load_on;

  gpdb_sync #(.W(NPINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_raw_i),
    .q_o   (pin_sync)
  );

  gpdb_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_val_i),
    .tick_o (tick_on),
    .cnt_o  (tick_cnt),
    .div_q_o(div_held)
  );

  always_comb begin
    load_on = (ld_q != LOAD_W'(LOAD_CYC));
    ld_d    = load_on ? ld_q + LOAD_W'(1) : ld_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ld_q <= '0;
    else         ld_q <= ld_d;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gpdb_pin_filter u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(load_on),
      .en_i  (dbnc_en_i[p]),
      .sel_i (slow_sel_i[p]),
      .tick_i(tick_on),
      .sync_i(pin_sync[p]),
      .filt_o(pin_filt_o[p])
    );
  end
endmodule

// File: rtl/gpio_debounce_filter_chk.sv
module gpio_debounce_filter_chk #(
  parameter int unsigned NPINS = 32,
  parameter int unsigned DIV_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NPINS-1:0] pin_filt_o,
  input logic [NPINS-1:0] dbnc_en_i,
  input logic [NPINS-1:0] slow_sel_i,
  input logic [DIV_W-1:0] div_val_i,
  input logic [NPINS-1:0] sync_v,
  input logic             load,
  input logic             tick,
  input logic [DIV_W:0]   cnt,
  input logic [DIV_W-1:0] div_q
);
  // R1
  load_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> !load);

  // R2
  pass_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_filt_o ^ $past(sync_v)) & $past(~dbnc_en_i)) == '0);

  // R3
  fast_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((pin_filt_o ^ $past(pin_filt_o)) & $past(dbnc_en_i & ~slow_sel_i & {NPINS{~load}}))
      & ((pin_filt_o ^ $past(sync_v)) | (pin_filt_o ^ $past(sync_v, 2)))) == '0);

  // R4
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick);

  // R5
  slow_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((pin_filt_o ^ $past(pin_filt_o)) & $past(dbnc_en_i & slow_sel_i & {NPINS{~load}})) != '0)
      |-> $past(tick));

  // R6
  div_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_val_i != div_q) |=> (cnt == '0));
endmodule

bind gpio_debounce_filter gpio_debounce_filter_chk #(.NPINS(NPINS), .DIV_W(DIV_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pin_filt_o(pin_filt_o),
  .dbnc_en_i (dbnc_en_i),
  .slow_sel_i(slow_sel_i),
  .div_val_i (div_val_i),
  .sync_v    (pin_sync),
  .load      (load_on),
  .tick      (tick_on),
  .cnt       (tick_cnt),
  .div_q     (div_held)
);

// File: tb/gpio_debounce_filter_bench.sv
`timescale 1ns/1ps
module gpio_debounce_filter_bench;
  localparam int NP = 4;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] raw = '0, en = '0, sel = '0;
  logic [DW-1:0] dv = '0;
  logic [NP-1:0] out;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit mon_on = 1'b0;
  logic [15:0] lf = 16'hACE1;

  always #4 clk = ~clk;

  gpio_debounce_filter #(.NPINS(NP), .DIV_W(DW)) u_gpio_debounce_filter (
    .clk_i(clk), .rst_ni(rst_n), .pin_raw_i(raw), .dbnc_en_i(en),
    .slow_sel_i(sel), .div_val_i(dv), .pin_filt_o(out)
  );

  // Cycle model built from the stated latencies and tick rules
  logic [NP-1:0] m1, m2, msamp, mout;
  logic [DW:0]   mcnt;
  logic [DW-1:0] mdiv;
  int            mld;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 = '0; m2 = '0; msamp = '0; mout = '0; mcnt = '0; mdiv = '0; mld = 0;
    end else begin
      bit chg, tk, ld;
      chg = (dv != mdiv);
      tk  = !chg && (int'(mcnt) == 2 * int'(dv) + 1);
      ld  = (mld < 3);
      for (int p = 0; p < NP; p++) begin
        if (ld || !en[p]) begin
          msamp[p] = m2[p]; mout[p] = m2[p];
        end else if (!sel[p] || tk) begin
          if (m2[p] == msamp[p]) mout[p] = m2[p];
          msamp[p] = m2[p];
        end
      end
      m2 = m1; m1 = raw;
      mcnt = (chg || tk) ? '0 : mcnt + 1'b1;
      mdiv = dv;
      if (mld < 3) mld++;
    end
  end

  task automatic chk(string req, logic [NP-1:0] got, logic [NP-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (mon_on) chk(tag, out, mout);

  function automatic logic [15:0] nxt(logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic hold_rand(int maxlen, int iters);
    for (int i = 0; i < iters; i++) begin
      lf = nxt(lf);
      raw = lf[NP-1:0];
      repeat ((lf[15:8] % maxlen) + 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state and load
    raw = 4'b1010;
    repeat (3) @(negedge clk);
    chk("R1 reset zero", out, 4'b0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 before load edge", out, 4'b0000);
    @(negedge clk);
    chk("R1 load", out, 4'b1010);
    mon_on = 1'b1;

    // R2: pass-through sweep and latency
    tag = "R2";
    for (int v = 0; v < 16; v++) begin raw = 4'(v); @(negedge clk); end
    repeat (4) @(negedge clk);
    raw = 4'b0101;
    repeat (2) @(negedge clk);
    chk("R2 two edges", out, 4'b1111);
    @(negedge clk);
    chk("R2 three edges", out, 4'b0101);

    // R3: raw-clock filtering
    tag = "R3";
    raw = 4'b0000; en = 4'hF; sel = 4'h0;
    repeat (6) @(negedge clk);
    raw = 4'b0001; @(negedge clk); raw = 4'b0000;
    for (int i = 0; i < 6; i++) begin @(negedge clk); chk("R3 pulse blocked", out, 4'b0000); end
    raw = 4'b0011;
    repeat (3) @(negedge clk);
    chk("R3 three edges", out, 4'b0000);
    @(negedge clk);
    chk("R3 four edges", out, 4'b0011);
    hold_rand(4, 200);

    // R4 R5: divided tick filtering at several divide values
    sel = 4'hF;
    for (int d = 0; d < 4; d++) begin
      tag = (d % 2 == 0) ? "R4" : "R5";
      dv = 4'(d);
      hold_rand(6 * (d + 1), 60);
    end

    // R8: all-ones divide value
    tag = "R8";
    dv = 4'hF;
    raw = 4'b0000; repeat (80) @(negedge clk);
    raw = 4'b1001; repeat (100) @(negedge clk);
    chk("R8 long period settles", out, 4'b1001);
    hold_rand(96, 30);

    // R6: divide value changes mid-count
    tag = "R6";
    for (int i = 0; i < 300; i++) begin
      lf = nxt(lf);
      raw = lf[NP-1:0];
      if (lf[15:13] == 3'd0) dv = 4'(lf[7:6]);
      @(negedge clk);
    end

    // R7: mixed per-pin modes
    tag = "R7";
    en = 4'b0110; sel = 4'b0100; dv = 4'd1;
    hold_rand(10, 150);

    // R1: reset mid-run with enables set, load ignores them
    tag = "R1";
    mon_on = 1'b0;
    raw = 4'b0110; en = 4'hF; sel = 4'hF; dv = 4'd3;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset zero again", out, 4'b0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 load ignores enables", out, 4'b0110);
    mon_on = 1'b1;
    hold_rand(12, 40);
    mon_on = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule